// File: doc/BRIEF.md
# Receive Clock-Compensation Elasticity Buffer

This block sits on the receive path after character decoding. Characters arrive on the recovered clock and leave on the local reference clock. Each character is nine bits: a special-character flag and a byte. The two clocks run at nearly the same rate, so the block keeps a small dual-clock store near half full. It absorbs the drift between the clocks only at framing-character boundaries. It drops a framing character when the store runs high, and it repeats one framing character when the store runs low.

The write and read pointers cross between the clock domains as Gray code through two-stage synchronizers. Each domain computes its own fill level. When compensation cannot keep up, the block raises a single-cycle error pulse on the side that saw the fault and moves that side's pointer back to half full.

When `en_i` is low, the store is idle. Incoming characters then pass through one register on the recovered clock.

Top module: `rx_elastic_buf`

## Requirements
- R1: With `en_i` low, `rd_valid_o`, `rd_k_o` and `rd_data_o` equal `wr_valid_i`, `wr_k_i` and `wr_data_i` as captured on the previous `wclk_i` rising edge. `ins_o`, `del_o`, `ovf_o` and `unf_o` stay low.
- R2: While `rst_ni` is low, `rd_valid_o` and all four status outputs are low. Reset places the pointers 8 entries apart and fills the store with framing characters. Within two reference cycles after release, the output is a valid framing character.
- R3: As long as no overflow or underflow occurs, every data character (`k`=0) written appears on the output exactly once and in write order.
- R4: A framing character is `k`=1 with byte 0xBC. An incoming framing character is discarded only when the write-side fill level is at least 12. Data characters are never discarded. `del_o` is high for one `wclk_i` cycle, in the cycle after the discarded character was presented.
- R5: Two successive framing writes are never both discarded, so `del_o` is never high in two consecutive write cycles.
- R6: When the character on the output is a framing character read from the store, and the read-side fill level is at most 4, the next output is an added framing character and the store is not read. `ins_o` is high in the same cycle as the added character. A character that was itself added is never followed by another added one.
- R7: A write presented when the write-side fill level is 16 is dropped. `ovf_o` pulses for one `wclk_i` cycle, and the write pointer moves to the synchronized read pointer plus 8.
- R8: A read cycle with fill level 0 and no insertion due outputs a framing character. `unf_o` pulses for one cycle, and the read pointer moves to the synchronized write pointer minus 8.
- R9: With `en_i` high and reset released, `rd_valid_o` is high in every `rclk_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered receive clock |
| rclk_i | input | 1 | Local reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Static: 1 selects the elasticity store, 0 selects pass-through |
| wr_valid_i | input | 1 | Incoming character strobe (wclk_i) |
| wr_k_i | input | 1 | Incoming special-character flag |
| wr_data_i | input | 8 | Incoming decoded byte |
| rd_valid_o | output | 1 | Outgoing character valid |
| rd_k_o | output | 1 | Outgoing special-character flag |
| rd_data_o | output | 8 | Outgoing byte |
| ins_o | output | 1 | Framing character added this cycle (rclk_i) |
| del_o | output | 1 | Framing character discarded (wclk_i) |
| ovf_o | output | 1 | Overflow pulse (wclk_i) |
| unf_o | output | 1 | Underflow pulse (rclk_i) |

## Verification
The bench drives three clock relations. With a faster write clock, a store that discards data characters, or that discards two framing characters in a row, breaks the ordered data scoreboard or trips the consecutive-discard check. With write gaps, insertion must occur and must follow a framing character; a design that inserts anywhere corrupts the order or shows a non-framing predecessor. Streams with no framing characters force overflow and underflow; missing pulses, or pulses longer than one cycle, are reported. A sweep over all 512 flag and byte combinations in pass-through catches a wrong bypass path or status leaking out of an idle store.

// File: rtl/esb_pkg.sv
`timescale 1ns/1ps
package esb_pkg;
  localparam logic [7:0] FRM_BYTE = 8'hBC;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } chr_t;

  localparam chr_t FRM_CHR = '{k: 1'b1, d: FRM_BYTE};
endpackage

// File: rtl/esb_sync.sv
`timescale 1ns/1ps
// two-stage synchronizer for a Gray pointer, binary out
module esb_sync #(
  parameter int PW = 5,
  parameter logic [PW-1:0] RST_GRAY = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_GRAY;
      s2_q <= RST_GRAY;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/esb_mem.sv
`timescale 1ns/1ps
module esb_mem
  import esb_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  chr_t          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output chr_t          rdata_o
);
  localparam int DEPTH = 1 << AW;

  chr_t mem_q [DEPTH];

  // preload idle framing so the output is defined right after reset
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= FRM_CHR;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/esb_wr_ctl.sv
`timescale 1ns/1ps
module esb_wr_ctl
  import esb_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DEL_TH = 12
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  chr_t          chr_i,
  input  logic [AW:0]   rptr_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output chr_t          wdata_o,
  output logic [AW:0]   wgray_o,
  output logic          del_o,
  output logic          ovf_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] NOM   = PW'(DEPTH / 2);
  localparam logic [PW-1:0] NOM_G = NOM ^ (NOM >> 1);

  logic [PW-1:0] wptr_q, wptr_d, wgray_q, fill;
  logic          last_del_q, del_q, ovf_q;
  logic          is_frm, do_del, do_ovf, do_wr;

  assign fill   = wptr_q - rptr_i;
  assign is_frm = chr_i.k && (chr_i.d == FRM_BYTE);
  assign do_del = en_i && valid_i && is_frm && !last_del_q && (fill >= PW'(DEL_TH));
  assign do_ovf = en_i && valid_i && !do_del && (fill == PW'(DEPTH));
  assign do_wr  = en_i && valid_i && !do_del && !do_ovf;

  always_comb begin
    if (!en_i)       wptr_d = NOM;
    else if (do_ovf) wptr_d = rptr_i + NOM;  // recentre
    else if (do_wr)  wptr_d = wptr_q + 1'b1;
    else             wptr_d = wptr_q;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= NOM;
      wgray_q    <= NOM_G;
      last_del_q <= 1'b0;
      del_q      <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wptr_d ^ (wptr_d >> 1);
      del_q   <= do_del;
      ovf_q   <= do_ovf;
      if (!en_i || do_wr) last_del_q <= 1'b0;
      else if (do_del)    last_del_q <= 1'b1;
    end
  end

  assign we_o    = do_wr;
  assign waddr_o = wptr_q[AW-1:0];
  assign wdata_o = chr_i;
  assign wgray_o = wgray_q;
  assign del_o   = del_q;
  assign ovf_o   = ovf_q;

  assert_del_rule_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    del_q |-> $past(valid_i && chr_i.k && chr_i.d == FRM_BYTE && fill >= PW'(DEL_TH)));
  assert_no_dbl_del_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    del_q |=> !del_q);
  assert_ovf_pulse_R7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q);
  assert_wgray_step_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !ovf_q |-> $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/esb_rd_ctl.sv
`timescale 1ns/1ps
module esb_rd_ctl
  import esb_pkg::*;
#(
  parameter int AW     = 4,
  parameter int INS_TH = 4
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW:0]   wptr_i,
  output logic [AW-1:0] raddr_o,
  input  chr_t          rdata_i,
  output logic [AW:0]   rgray_o,
  output chr_t          chr_o,
  output logic          valid_o,
  output logic          ins_o,
  output logic          unf_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] NOM = PW'(DEPTH / 2);

  logic [PW-1:0] rptr_q, rptr_d, rgray_q, fill;
  logic          last_frm_q, valid_q, ins_q, unf_q;
  chr_t          chr_q;
  logic          rd_frm, do_ins, do_unf, do_rd;

  assign fill   = wptr_i - rptr_q;
  assign rd_frm = rdata_i.k && (rdata_i.d == FRM_BYTE);
  assign do_ins = en_i && last_frm_q && (fill <= PW'(INS_TH));
  assign do_unf = en_i && !do_ins && (fill == '0);
  assign do_rd  = en_i && !do_ins && !do_unf;

  always_comb begin
    if (!en_i)       rptr_d = '0;
    else if (do_unf) rptr_d = wptr_i - NOM;  // recentre
    else if (do_rd)  rptr_d = rptr_q + 1'b1;
    else             rptr_d = rptr_q;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q     <= '0;
      rgray_q    <= '0;
      last_frm_q <= 1'b0;
      valid_q    <= 1'b0;
      ins_q      <= 1'b0;
      unf_q      <= 1'b0;
      chr_q      <= FRM_CHR;
    end else begin
      rptr_q     <= rptr_d;
      rgray_q    <= rptr_d ^ (rptr_d >> 1);
      valid_q    <= en_i;
      ins_q      <= do_ins;
      unf_q      <= do_unf;
      chr_q      <= do_rd ? rdata_i : FRM_CHR;
      // only a framing char taken from the store arms an insertion
      last_frm_q <= do_rd && rd_frm;
    end
  end

  assign raddr_o = rptr_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign chr_o   = chr_q;
  assign valid_o = valid_q;
  assign ins_o   = ins_q;
  assign unf_o   = unf_q;

  assert_one_ins_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ins_q |=> !ins_q);
  assert_unf_pulse_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    unf_q |=> !unf_q);
  assert_valid_R9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    en_i |=> valid_q);
  assert_rgray_step_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !unf_q |-> $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/rx_elastic_buf.sv
`timescale 1ns/1ps
module rx_elastic_buf
  import esb_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DEL_TH = 12,
  parameter int INS_TH = 4
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_valid_i,
  input  logic       wr_k_i,
  input  logic [7:0] wr_data_i,
  output logic       rd_valid_o,
  output logic       rd_k_o,
  output logic [7:0] rd_data_o,
  output logic       ins_o,
  output logic       del_o,
  output logic       ovf_o,
  output logic       unf_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] NOM   = PW'((1 << AW) / 2);
  localparam logic [PW-1:0] NOM_G = NOM ^ (NOM >> 1);

  chr_t          wchr, wdata, rdata, rchr, byp_q;
  logic          we, rvalid, byp_vld_q;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wptr_sync, rptr_sync;

  assign wchr = '{k: wr_k_i, d: wr_data_i};

  esb_wr_ctl #(.AW(AW), .DEL_TH(DEL_TH)) i_wr_ctl (
    .wclk_i, .rst_ni, .en_i,
    .valid_i (wr_valid_i),
    .chr_i   (wchr),
    .rptr_i  (rptr_sync),
    .we_o    (we),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .wgray_o (wgray),
    .del_o, .ovf_o
  );

  esb_mem #(.AW(AW)) i_mem (
    .wclk_i, .rst_ni,
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  esb_sync #(.PW(PW), .RST_GRAY(NOM_G)) i_sync_w2r (
    .clk_i (rclk_i), .rst_ni, .gray_i (wgray), .bin_o (wptr_sync)
  );

  esb_sync #(.PW(PW), .RST_GRAY('0)) i_sync_r2w (
    .clk_i (wclk_i), .rst_ni, .gray_i (rgray), .bin_o (rptr_sync)
  );

  esb_rd_ctl #(.AW(AW), .INS_TH(INS_TH)) i_rd_ctl (
    .rclk_i, .rst_ni, .en_i,
    .wptr_i  (wptr_sync),
    .raddr_o (raddr),
    .rdata_i (rdata),
    .rgray_o (rgray),
    .chr_o   (rchr),
    .valid_o (rvalid),
    .ins_o, .unf_o
  );

  // pass-through register on the recovered clock
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q     <= FRM_CHR;
      byp_vld_q <= 1'b0;
    end else begin
      byp_q     <= wchr;
      byp_vld_q <= wr_valid_i;
    end
  end

  assign rd_valid_o = en_i ? rvalid : byp_vld_q;
  assign rd_k_o     = en_i ? rchr.k : byp_q.k;
  assign rd_data_o  = en_i ? rchr.d : byp_q.d;

  assert_byp_quiet_R1: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !en_i |-> !ins_o && !unf_o);
endmodule

// File: tb/test_rx_elastic_buf.sv
`timescale 1ns/1ps
module test_rx_elastic_buf;
  logic       wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0, en_i = 1'b1;
  logic       wr_valid_i = 1'b0, wr_k_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_valid_o, rd_k_o, ins_o, del_o, ovf_o, unf_o;
  logic [7:0] rd_data_o;

  int   n_chk = 0, n_bad = 0;
  int   ins_n, del_n, ovf_n, unf_n;
  bit   sb_on = 0, buf_mode = 0, done = 0;
  bit   prev_frm, prev_del, prev_ovf;
  real  wclk_half = 4.0;
  logic [7:0] exp_q[$];

  rx_elastic_buf i_rx_elastic_buf (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni, .en_i,
    .wr_valid_i, .wr_k_i, .wr_data_i,
    .rd_valid_o, .rd_k_o, .rd_data_o,
    .ins_o, .del_o, .ovf_o, .unf_o
  );

  always #4 rclk = ~rclk;  // 125 MHz reference
  initial begin
    #3;
    forever #(wclk_half) wclk = ~wclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference-side monitor
  always @(posedge rclk) begin
    #1;
    if (buf_mode && rst_ni) begin
      if (!rd_valid_o) chk("R9 valid every cycle", rd_valid_o, 1);
      if (ins_o) begin
        ins_n++;
        chk("R6 added char is framing", {rd_k_o, rd_data_o}, 9'h1BC);
        chk("R6 added after framing", prev_frm, 1);
      end
      if (unf_o) begin
        unf_n++;
        chk("R8 underflow char is framing", {rd_k_o, rd_data_o}, 9'h1BC);
      end
      if (sb_on && !rd_k_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R3 extra data: actual=%h expected=none", rd_data_o);
        end else begin
          chk("R3 data order", rd_data_o, exp_q.pop_front());
        end
      end
      prev_frm = rd_k_o && rd_data_o == 8'hBC;
    end
  end

  // recovered-side monitor
  always @(posedge wclk) begin
    #1;
    if (buf_mode && rst_ni) begin
      if (del_o) begin
        del_n++;
        chk("R4 discarded char is framing", {wr_valid_i, wr_k_i, wr_data_i}, 10'h3BC);
        chk("R5 no consecutive discards", prev_del, 0);
      end
      if (ovf_o) begin
        ovf_n++;
        chk("R7 single overflow pulse", prev_ovf, 0);
      end
      prev_del = del_o;
      prev_ovf = ovf_o;
    end
  end

  task automatic put(input logic v, input logic k, input logic [7:0] d);
    @(negedge wclk);
    wr_valid_i = v; wr_k_i = k; wr_data_i = d;
    if (sb_on && v && !k) exp_q.push_back(d);
  endtask

  task automatic apply_reset(input bit en, input real half);
    buf_mode = 0; sb_on = 0;
    @(negedge rclk);
    rst_ni = 0; wr_valid_i = 0; en_i = en; wclk_half = half;
    exp_q.delete();
    ins_n = 0; del_n = 0; ovf_n = 0; unf_n = 0;
    prev_frm = 0; prev_del = 0; prev_ovf = 0;
    repeat (4) @(negedge rclk);
    chk("R2 outputs quiet in reset",
        {rd_valid_o, ins_o, del_o, ovf_o, unf_o}, 0);
    #1.25;  // off both clock grids
    rst_ni = 1;
    buf_mode = en;
  endtask

  // pat 0: data only; 1: F D D D; 2: F F D D. gap>0: idle slot every gap chars
  task automatic stream(input int n, input int gap, input int pat);
    for (int i = 0; i < n; i++) begin
      bit frm;
      case (pat)
        0:       frm = 0;
        1:       frm = (i % 4 == 0);
        default: frm = (i % 4 < 2);
      endcase
      if (gap != 0 && i % gap == gap - 1) put(0, 0, 8'h00);
      if (frm) put(1, 1, 8'hBC);
      else     put(1, 0, 8'(i));
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 48; i++) put(1, 1, 8'hBC);
    repeat (8) @(posedge rclk);
    #1;
    chk("R3 all data delivered", exp_q.size(), 0);
    sb_on = 0;
    put(0, 0, 8'h00);
  endtask

  initial begin
    // reset state and balanced clocks
    apply_reset(1, 4.0);
    repeat (2) @(posedge rclk);
    #1;
    chk("R2 framing out after release", {rd_valid_o, rd_k_o, rd_data_o}, 10'h3BC);
    sb_on = 1;
    stream(2000, 0, 1);
    flush();
    chk("R7 no overflow balanced", ovf_n, 0);
    chk("R8 no underflow balanced", unf_n, 0);

    // slower writer: insertion expected
    apply_reset(1, 4.0);
    sb_on = 1;
    stream(2000, 8, 1);
    flush();
    chk("R6 insertions occurred", ins_n > 0, 1);
    chk("R8 no underflow slow", unf_n, 0);

    // faster writer with paired framing: deletion expected
    apply_reset(1, 3.5);
    sb_on = 1;
    stream(2400, 0, 2);
    flush();
    chk("R4 deletions occurred", del_n > 0, 1);
    chk("R7 no overflow fast", ovf_n, 0);

    // faster writer, no framing: overflow
    apply_reset(1, 3.5);
    stream(600, 0, 0);
    put(0, 0, 8'h00);
    chk("R7 overflow raised", ovf_n > 0, 1);

    // slow writer, no framing: underflow
    apply_reset(1, 4.0);
    stream(300, 1, 0);
    put(0, 0, 8'h00);
    chk("R8 underflow raised", unf_n > 0, 1);

    // pass-through sweep over every flag/byte
    apply_reset(0, 4.0);
    for (int v = 0; v < 512; v++) begin
      logic vl, kk;
      logic [7:0] dd;
      vl = (v % 3 != 2); kk = v[8]; dd = v[7:0];
      @(negedge wclk);
      wr_valid_i = vl; wr_k_i = kk; wr_data_i = dd;
      @(posedge wclk);
      #1;
      chk("R1 pass-through", {rd_valid_o, rd_k_o, rd_data_o}, {vl, kk, dd});
      chk("R1 status quiet", {ins_o, del_o, ovf_o, unf_o}, 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..R9 run: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule